// File: doc/BRIEF.md
# Masked Time-Match Alarm Unit

This block watches the running time of a calendar clock (seconds, minutes, hours and day of month, all in BCD) and raises an alarm flag when the time matches a programmed alarm setting. Four alarm registers hold the target seconds, minutes, hours and date. The top bit of each register is a mask bit. Together the four mask bits form a code that sets how often the alarm repeats: every second, every minute, every hour, every day, or once a month.

The clock supplies a one-cycle tick each time its time fields advance. The comparison is made only on that tick, so the alarm fires at most once for each matching second. The block also holds two enable bits, one for normal operation and one for battery-backup operation. A power-up pulse clears both enables but leaves the alarm flag untouched, so software can still see an alarm that arrived while power was returning. Reading the flags register clears the flag. The interrupt request is the flag gated by whichever enable suits the present power mode.

Top module: `tmatch_alarm`

## Requirements
- R1: After reset the alarm flag, both enable bits and the interrupt request are 0, and all four alarm registers are 0.
- R2: With the mask code {date bit7, hours bit7, minutes bit7, seconds bit7} = 1111, every tick sets the alarm flag, whatever the time.
- R3: With mask code 1110, a tick sets the flag only when the seconds field (bits 6:0) equals the seconds alarm register bits 6:0.
- R4: With mask code 1100, a tick sets the flag only when both seconds and minutes (bits 6:0) match their alarm registers.
- R5: With mask code 1000, a tick sets the flag only when seconds, minutes and hours (bits 6:0) all match.
- R6: With mask code 0000, a tick sets the flag only when date, hours, minutes and seconds (bits 6:0) all match.
- R7: Any mask code other than 1111, 1110, 1100, 1000 or 0000 behaves as 1111: every tick sets the flag.
- R8: Without a tick the flag is never set, even if the time matches; after a tick at a clock edge the flag reads 1 from that edge on.
- R9: A read strobe clears the flag at the next edge; when a read strobe and a setting tick come in the same cycle, the flag ends up 1.
- R10: A write with select 0, 1, 2 or 3 loads the seconds, minutes, hours or date alarm register; select 4 loads the enables from data bit 7 (normal enable) and bit 6 (backup enable); selects 5 to 7 change nothing.
- R11: A power-up pulse clears both enable bits at the next edge, winning over a write to select 4 in the same cycle, and leaves the flag unchanged; a setting tick during the pulse still sets the flag.
- R12: The interrupt request equals the flag ANDed with the normal enable when the backup input is 0, and with the backup enable when it is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hr_i | input | 8 | Current hours, BCD, 24-hour |
| date_i | input | 8 | Current day of month, BCD |
| tick_i | input | 1 | One-cycle pulse: time fields hold the new second |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| flag_rd_i | input | 1 | Flags register read strobe, clears the flag |
| pwr_up_i | input | 1 | Power-up event pulse |
| backup_i | input | 1 | 1 while running on backup supply |
| alarm_flag_o | output | 1 | Alarm flag |
| alarm_en_o | output | 1 | Normal-mode alarm enable |
| backup_en_o | output | 1 | Backup-mode alarm enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Every registered result (flag, enables, alarm registers) is due one clock edge after the cycle that carries the tick, write, read or power-up pulse, while the interrupt request follows the flag, the enables and the backup input in the same cycle. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each registered check lands exactly one edge after its stimulus and each interrupt check reads a settled combinational value. The no-tick case is read at that same point to show that a matching time alone left the flag at 0.

// File: rtl/tmatch_pkg.sv
// Shared widths, register selects and the alarm register bundle.
package tmatch_pkg;
    localparam int DW   = 8;
    localparam int SELW = 3;

    typedef enum logic [SELW-1:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HR   = 3'd2,
        SEL_DATE = 3'd3,
        SEL_INTR = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] date;
        logic [DW-1:0] hr;
        logic [DW-1:0] min;
        logic [DW-1:0] sec;
    } alm_regs_t;
endpackage

// File: rtl/tmatch_regs.sv
// Alarm register file: four alarm registers (top bit = mask bit) and the
// two enable bits. Assumes one write per cycle; power-up beats a write.
module tmatch_regs
    import tmatch_pkg::*;
#(
    parameter int NFIELD = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            pwr_up,
    output alm_regs_t       regs,
    output logic [NFIELD-1:0] mask,
    output logic            alarm_en,
    output logic            backup_en
);
    logic [DW-1:0] alm_q [NFIELD];

    for (genvar g = 0; g < NFIELD; g++) begin : g_alm
        // Load one alarm register when its select is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm_q[g] <= '0;
            else if (wr_en && wr_sel == SELW'(g))
                alm_q[g] <= wr_data;
        end
        assign mask[g] = alm_q[g][DW-1];
    end

    assign regs.sec  = alm_q[0];
    assign regs.min  = alm_q[1];
    assign regs.hr   = alm_q[2];
    assign regs.date = alm_q[3];

    // Enable bits: cleared by reset or power-up, else loaded by select 4.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_up) begin
            alarm_en  <= 1'b0;
            backup_en <= 1'b0;
        end else if (wr_en && wr_sel == SEL_INTR) begin
            alarm_en  <= wr_data[DW-1];
            backup_en <= wr_data[DW-2];
        end
    end
endmodule

// File: rtl/tmatch_cmp.sv
// Masked comparator: decodes the mask code into a repeat rate and compares
// the time fields (top bit excluded) against the alarm registers.
// Unlisted mask codes fall back to once per second.
module tmatch_cmp
    import tmatch_pkg::*;
(
    input  logic [DW-1:0] sec,
    input  logic [DW-1:0] min,
    input  logic [DW-1:0] hr,
    input  logic [DW-1:0] date,
    input  alm_regs_t     regs,
    input  logic [3:0]    mask,
    output logic          match
);
    logic eq_s, eq_m, eq_h, eq_d;

    // Per-field equality on the value bits only.
    always_comb begin
        eq_s = sec[DW-2:0]  == regs.sec[DW-2:0];
        eq_m = min[DW-2:0]  == regs.min[DW-2:0];
        eq_h = hr[DW-2:0]   == regs.hr[DW-2:0];
        eq_d = date[DW-2:0] == regs.date[DW-2:0];
    end

    // Repeat-rate decode.
    always_comb begin
        unique case (mask)
            4'b1110: match = eq_s;
            4'b1100: match = eq_s && eq_m;
            4'b1000: match = eq_s && eq_m && eq_h;
            4'b0000: match = eq_s && eq_m && eq_h && eq_d;
            default: match = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmatch_flag.sv
// Alarm flag: set on a tick that matches, cleared by a read strobe.
// A set in the same cycle as a read wins so no alarm is lost.
module tmatch_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic rd,
    output logic flag
);
    // Set-dominant flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (tick && match)
            flag <= 1'b1;
        else if (rd)
            flag <= 1'b0;
    end
endmodule

// File: rtl/tmatch_alarm.sv
// Top of the masked time-match alarm unit. Assumes the time inputs already
// hold the new second while tick_i is high.
module tmatch_alarm
    import tmatch_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   sec_i,
    input  logic [DW-1:0]   min_i,
    input  logic [DW-1:0]   hr_i,
    input  logic [DW-1:0]   date_i,
    input  logic            tick_i,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic            flag_rd_i,
    input  logic            pwr_up_i,
    input  logic            backup_i,
    output logic            alarm_flag_o,
    output logic            alarm_en_o,
    output logic            backup_en_o,
    output logic            irq_o
);
    alm_regs_t  regs;
    logic [3:0] mask_code;
    logic       hit;

    tmatch_regs #(.NFIELD(4)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
        .wr_data(wr_data_i), .pwr_up(pwr_up_i), .regs(regs),
        .mask(mask_code), .alarm_en(alarm_en_o), .backup_en(backup_en_o)
    );

    tmatch_cmp u_cmp (
        .sec(sec_i), .min(min_i), .hr(hr_i), .date(date_i),
        .regs(regs), .mask(mask_code), .match(hit)
    );

    tmatch_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(tick_i), .match(hit),
        .rd(flag_rd_i), .flag(alarm_flag_o)
    );

    // Interrupt gate: enable chosen by the present power mode.
    always_comb begin
        irq_o = alarm_flag_o && (backup_i ? backup_en_o : alarm_en_o);
    end
endmodule

// File: rtl/tmatch_alarm_chk.sv
// Checker for the alarm unit, bound into every instance of the top.
module tmatch_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       flag_rd_i,
    input logic       pwr_up_i,
    input logic [3:0] mask_code,
    input logic       alarm_flag_o,
    input logic       alarm_en_o,
    input logic       backup_en_o,
    input logic       irq_o
);
    AST_PWRUP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up_i |=> (!alarm_en_o && !backup_en_o)); // R11
    AST_PWRUP_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up_i && alarm_flag_o && !flag_rd_i) |=> alarm_flag_o); // R11
    AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag_o && !tick_i) |=> !alarm_flag_o); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd_i && !tick_i) |=> !alarm_flag_o); // R9
    AST_ALL_ONES_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mask_code == 4'b1111) |=> alarm_flag_o); // R2
    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_flag_o |-> !irq_o); // R12
endmodule

bind tmatch_alarm tmatch_alarm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .flag_rd_i(flag_rd_i),
    .pwr_up_i(pwr_up_i), .mask_code(mask_code), .alarm_flag_o(alarm_flag_o),
    .alarm_en_o(alarm_en_o), .backup_en_o(backup_en_o), .irq_o(irq_o)
);

// File: tb/tmatch_alarm_test.sv
module tmatch_alarm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sec_i = '0, min_i = '0, hr_i = '0, date_i = '0;
    logic       tick_i = 1'b0, wr_en_i = 1'b0, flag_rd_i = 1'b0;
    logic       pwr_up_i = 1'b0, backup_i = 1'b0;
    logic [2:0] wr_sel_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       alarm_flag_o, alarm_en_o, backup_en_o, irq_o;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    tmatch_alarm uut (
        .clk(clk), .rst_n(rst_n), .sec_i(sec_i), .min_i(min_i), .hr_i(hr_i),
        .date_i(date_i), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .flag_rd_i(flag_rd_i), .pwr_up_i(pwr_up_i),
        .backup_i(backup_i), .alarm_flag_o(alarm_flag_o), .alarm_en_o(alarm_en_o),
        .backup_en_o(backup_en_o), .irq_o(irq_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Alarm target 08:15:30 on date 21; mask bits given as {m4,m3,m2,m1}.
    task automatic set_alarm(input logic [3:0] m);
        write_reg(3'd0, {m[0], 7'h30});
        write_reg(3'd1, {m[1], 7'h15});
        write_reg(3'd2, {m[2], 7'h08});
        write_reg(3'd3, {m[3], 7'h21});
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_rd_i = 1'b1;
        @(negedge clk); flag_rd_i = 1'b0;
    endtask

    // One tick with the given time; flag read one edge later.
    task automatic tick_at(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] d);
        @(negedge clk);
        sec_i = s; min_i = m; hr_i = h; date_i = d; tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset();
        check(alarm_flag_o, 1'b0, "R1 flag");
        check(alarm_en_o, 1'b0, "R1 alarm_en");
        check(backup_en_o, 1'b0, "R1 backup_en");
        check(irq_o, 1'b0, "R1 irq");
        // all-zero alarm regs = mask 0000 at 00:00:00 date 00: must match
        tick_at(8'h00, 8'h00, 8'h00, 8'h00);
        check(alarm_flag_o, 1'b1, "R1 zero alarm regs");
        clear_flag();
    endtask

    task automatic t_every_second();
        set_alarm(4'b1111);
        tick_at(8'h59, 8'h42, 8'h17, 8'h03);
        check(alarm_flag_o, 1'b1, "R2 mask 1111");
        clear_flag();
        check(alarm_flag_o, 1'b0, "R9 read clears");
    endtask

    task automatic t_seconds();
        set_alarm(4'b1110);
        tick_at(8'h30, 8'h44, 8'h19, 8'h02);
        check(alarm_flag_o, 1'b1, "R3 seconds hit");
        clear_flag();
        tick_at(8'h31, 8'h15, 8'h08, 8'h21);
        check(alarm_flag_o, 1'b0, "R3 seconds miss");
    endtask

    task automatic t_minutes();
        set_alarm(4'b1100);
        tick_at(8'h30, 8'h15, 8'h19, 8'h02);
        check(alarm_flag_o, 1'b1, "R4 min+sec hit");
        clear_flag();
        tick_at(8'h30, 8'h16, 8'h08, 8'h21);
        check(alarm_flag_o, 1'b0, "R4 minutes miss");
    endtask

    task automatic t_hours();
        set_alarm(4'b1000);
        tick_at(8'h30, 8'h15, 8'h08, 8'h02);
        check(alarm_flag_o, 1'b1, "R5 h+m+s hit");
        clear_flag();
        tick_at(8'h30, 8'h15, 8'h09, 8'h21);
        check(alarm_flag_o, 1'b0, "R5 hours miss");
    endtask

    task automatic t_date();
        set_alarm(4'b0000);
        tick_at(8'h30, 8'h15, 8'h08, 8'h21);
        check(alarm_flag_o, 1'b1, "R6 full hit");
        clear_flag();
        tick_at(8'h30, 8'h15, 8'h08, 8'h22);
        check(alarm_flag_o, 1'b0, "R6 date miss");
    endtask

    task automatic t_illegal();
        set_alarm(4'b1010);
        tick_at(8'h01, 8'h02, 8'h03, 8'h04);
        check(alarm_flag_o, 1'b1, "R7 code 1010");
        clear_flag();
        set_alarm(4'b0111);
        tick_at(8'h01, 8'h02, 8'h03, 8'h04);
        check(alarm_flag_o, 1'b1, "R7 code 0111");
        clear_flag();
    endtask

    task automatic t_no_tick();
        set_alarm(4'b0000);
        @(negedge clk);
        sec_i = 8'h30; min_i = 8'h15; hr_i = 8'h08; date_i = 8'h21;
        @(negedge clk);
        check(alarm_flag_o, 1'b0, "R8 match without tick");
        tick_i = 1'b1;
        check(alarm_flag_o, 1'b0, "R8 not before edge");
        @(negedge clk);
        tick_i = 1'b0;
        check(alarm_flag_o, 1'b1, "R8 set after edge");
    endtask

    task automatic t_read_race();
        set_alarm(4'b1111);
        @(negedge clk);
        tick_i = 1'b1; flag_rd_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0; flag_rd_i = 1'b0;
        check(alarm_flag_o, 1'b1, "R9 set beats read");
        clear_flag();
        check(alarm_flag_o, 1'b0, "R9 read after race");
    endtask

    task automatic t_enables();
        write_reg(3'd4, 8'hC0);
        check(alarm_en_o, 1'b1, "R10 alarm_en set");
        check(backup_en_o, 1'b1, "R10 backup_en set");
        write_reg(3'd5, 8'h00);
        write_reg(3'd7, 8'h00);
        check(alarm_en_o, 1'b1, "R10 sel 5/7 ignored");
        write_reg(3'd4, 8'h40);
        check(alarm_en_o, 1'b0, "R10 alarm_en cleared");
        check(backup_en_o, 1'b1, "R10 backup_en kept");
    endtask

    task automatic t_power_up();
        write_reg(3'd4, 8'hC0);
        set_alarm(4'b1111);
        tick_at(8'h00, 8'h00, 8'h00, 8'h01);
        @(negedge clk); pwr_up_i = 1'b1;
        @(negedge clk); pwr_up_i = 1'b0;
        check(alarm_en_o, 1'b0, "R11 alarm_en cleared");
        check(backup_en_o, 1'b0, "R11 backup_en cleared");
        check(alarm_flag_o, 1'b1, "R11 flag kept");
        clear_flag();
        @(negedge clk);
        pwr_up_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd4; wr_data_i = 8'hC0;
        tick_i = 1'b1;
        @(negedge clk);
        pwr_up_i = 1'b0; wr_en_i = 1'b0; tick_i = 1'b0;
        check(alarm_en_o, 1'b0, "R11 power-up beats write");
        check(alarm_flag_o, 1'b1, "R11 alarm during power-up");
    endtask

    task automatic t_irq();
        // flag is 1 here
        write_reg(3'd4, 8'h80);
        backup_i = 1'b0; #1;
        check(irq_o, 1'b1, "R12 normal mode irq");
        backup_i = 1'b1; #1;
        check(irq_o, 1'b0, "R12 backup mode masked");
        write_reg(3'd4, 8'h40);
        check(irq_o, 1'b1, "R12 backup mode irq");
        backup_i = 1'b0; #1;
        check(irq_o, 1'b0, "R12 normal mode masked");
        write_reg(3'd4, 8'hC0);
        clear_flag();
        check(irq_o, 1'b0, "R12 no flag no irq");
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_every_second();
        t_seconds();
        t_minutes();
        t_hours();
        t_date();
        t_illegal();
        clear_flag();
        t_no_tick();
        clear_flag();
        t_read_race();
        t_enables();
        t_power_up();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule